// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This unit carries out one memory transfer of a 32-bit load/store instruction: a single register, or an even/odd register pair. Decode has already split the instruction into fields: a condition-pass bit, pre/post indexing, offset direction, base update, the three register numbers, an immediate or an already shifted register offset, the access size and a sign flag. The register file supplies the base value, the offset register value, the program counter and the one or two source values for a store.

The unit computes the access address and, when needed, the updated base. It drives a request/acknowledge memory port with byte enables and returns load data to a register write port. The updated base goes out on a second write port. A word load aimed at the program counter becomes a branch. Illegal register combinations are flagged as unpredictable, and the instruction then has no side effect. An instruction whose condition failed completes quietly.

Top module: `ldst_addr_unit`

## Requirements
- R1: The offset address is base + offset when `up`=1 and base − offset when `up`=0. The access uses the offset address when `pre_idx`=1 and the unmodified base when `pre_idx`=0.
- R2: For a non-literal form with `pre_idx`=0 or `wb`=1, the unit pulses `wb_we` once, in the same cycle as `done`, with `wb_waddr`=`base_idx` and `wb_wdata`= the offset address. Otherwise `wb_we` stays low.
- R3: When `literal`=1, the base is `pc_val` with bits [1:0] cleared, the access always uses the offset address, and no writeback happens, whatever `pre_idx` and `wb` are.
- R4: When `off_is_reg`=1, the offset is `off_val`. Otherwise it comes from `imm`: all 12 bits for word and unsigned-byte accesses, and `{imm[11:8], imm[3:0]}` for halfword, any signed, and pair accesses.
- R5: `size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = pair. A byte load takes the lane `mem_rdata[8*a+7:8*a]` with a = addr[1:0]. A halfword load takes `mem_rdata[31:16]` if addr[1]=1, else `mem_rdata[15:0]`. The value is sign-extended when `sign_ext`=1 and zero-extended otherwise.
- R6: A store drives `mem_we`=1. A byte store uses `mem_be`=1<<addr[1:0] with the low byte of `st_data0` copied to all four lanes. A halfword store uses `mem_be`=4'b1100 (addr[1]=1) or 4'b0011 with the low half copied to both halves. Word and pair beats use 4'b1111.
- R7: A pair transfer makes two beats, at the access address and at that address + 4. A load writes register `tgt_idx` from the first beat and `tgt_idx`+1 from the second. A store sends `st_data0` and then `st_data1`.
- R8: `unpred` is raised with `done` when any of these holds: writeback is active and `base_idx` equals `tgt_idx`, or equals `tgt_idx`+1 for a pair; `off_is_reg`=1 with `off_idx`=15; a pair with an odd `tgt_idx` or with `tgt_idx`=14; a non-literal pair with `pre_idx`=0 and `wb`=1.
- R9: When `cond_ok`=0 or the instruction is unpredictable, no memory request, register write, writeback or branch happens. `done` still pulses one cycle after acceptance.
- R10: A single word load with `tgt_idx`=15 pulses `br_valid` with `br_target` = the loaded word, and makes no register write.
- R11: `mem_req` is held with a stable address until `mem_ack`. `busy` is high from the cycle after `start` is accepted until the cycle `done` pulses. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue the instruction on the field inputs (accepted when idle) |
| cond_ok | input | 1 | Condition check passed |
| is_load | input | 1 | 1 = load, 0 = store |
| literal | input | 1 | PC-relative form |
| pre_idx | input | 1 | Access at offset address (pre-index) |
| up | input | 1 | Add offset (1) or subtract (0) |
| wb | input | 1 | Base update requested |
| size | input | 2 | 0 byte, 1 half, 2 word, 3 pair |
| sign_ext | input | 1 | Sign-extend loaded byte/half |
| base_idx | input | 4 | Base register number |
| tgt_idx | input | 4 | Target (first) register number |
| off_idx | input | 4 | Offset register number |
| off_is_reg | input | 1 | Offset from register value |
| imm | input | 12 | Immediate field |
| base_val | input | 32 | Base register value |
| off_val | input | 32 | Shifted offset register value |
| pc_val | input | 32 | Program counter value |
| st_data0 | input | 32 | Store value of first register |
| st_data1 | input | 32 | Store value of second register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| unpred | output | 1 | Instruction was unpredictable (with done) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| rf_we | output | 1 | Load data write strobe |
| rf_waddr | output | 4 | Load destination register |
| rf_wdata | output | 32 | Formatted load data |
| wb_we | output | 1 | Base writeback strobe |
| wb_waddr | output | 4 | Base register number |
| wb_wdata | output | 32 | Updated base |
| br_valid | output | 1 | Branch to loaded value |
| br_target | output | 32 | Branch target |

## Verification
Random instructions exercise post-indexed accesses, where a design that used the offset address would touch the wrong word, and literal forms with a misaligned PC, where a missing alignment moves the address by up to three bytes. Directed cases cover a pair whose base overlaps the second register, an odd or index-14 pair target, and an offset register of 15. A unit that missed any of these would write memory or registers it must leave alone. Byte and halfword loads with the top lane bit set are checked for sign extension, and for lane selection at every low-address value. A second `start` pulse with scrambled fields during a busy cycle must leave the running transfer unchanged.

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cond_ok,
  input  logic        is_load,
  input  logic        literal,
  input  logic        pre_idx,
  input  logic        up,
  input  logic        wb,
  input  logic [1:0]  size,
  input  logic        sign_ext,
  input  logic [3:0]  base_idx,
  input  logic [3:0]  tgt_idx,
  input  logic [3:0]  off_idx,
  input  logic        off_is_reg,
  input  logic [11:0] imm,
  input  logic [31:0] base_val,
  input  logic [31:0] off_val,
  input  logic [31:0] pc_val,
  input  logic [31:0] st_data0,
  input  logic [31:0] st_data1,
  output logic        busy,
  output logic        done,
  output logic        unpred,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        rf_we,
  output logic [3:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic        wb_we,
  output logic [3:0]  wb_waddr,
  output logic [31:0] wb_wdata,
  output logic        br_valid,
  output logic [31:0] br_target
);

  typedef enum logic [1:0] {S_IDLE, S_BEAT0, S_BEAT1, S_SKIP} state_t;
  state_t st;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_PAIR = 2'd3;
  localparam logic [3:0] PC_IDX  = 4'd15;

  // issue-time address arithmetic
  logic        narrow, pair_in, wben, bad;
  logic [31:0] offset, base, off_addr, acc_addr;

  assign pair_in  = (size == SZ_PAIR);
  assign narrow   = (size == SZ_HALF) || pair_in || sign_ext;
  assign offset   = off_is_reg ? off_val :
                    narrow     ? {24'd0, imm[11:8], imm[3:0]} : {20'd0, imm};
  assign base     = literal ? {pc_val[31:2], 2'b00} : base_val;
  assign off_addr = up ? base + offset : base - offset;
  assign acc_addr = (literal || pre_idx) ? off_addr : base;
  assign wben     = !literal && (!pre_idx || wb);
  assign bad      = (wben && (base_idx == tgt_idx || (pair_in && base_idx == (tgt_idx | 4'd1))))
                 || (off_is_reg && off_idx == PC_IDX)
                 || (pair_in && (tgt_idx[0] || tgt_idx == 4'd14))
                 || (pair_in && !literal && !pre_idx && wb);

  // latched instruction
  logic [31:0] addr_q, oaddr_q, d0_q, d1_q;
  logic [3:0]  tgt_q, bidx_q;
  logic [1:0]  size_q;
  logic        sign_q, load_q, wben_q, bad_q;
  logic        pair_q;

  assign pair_q = (size_q == SZ_PAIR);

  // memory port
  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_BEAT0) || (st == S_BEAT1);
  assign mem_we   = !load_q;
  assign mem_addr = (st == S_BEAT1) ? addr_q + 32'd4 : addr_q;

  always_comb begin
    case (size_q)
      SZ_BYTE: mem_be = 4'b0001 << addr_q[1:0];
      SZ_HALF: mem_be = addr_q[1] ? 4'b1100 : 4'b0011;
      default: mem_be = 4'b1111;
    endcase
  end

  always_comb begin
    if (st == S_BEAT1)          mem_wdata = d1_q;
    else if (size_q == SZ_BYTE) mem_wdata = {4{d0_q[7:0]}};
    else if (size_q == SZ_HALF) mem_wdata = {2{d0_q[15:0]}};
    else                        mem_wdata = d0_q;
  end

  // load data formatting
  logic [31:0] lane_sh, ld_fmt;
  logic [15:0] half_sel;
  assign lane_sh  = mem_rdata >> {addr_q[1:0], 3'b000};
  assign half_sel = addr_q[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (size_q)
      SZ_BYTE: ld_fmt = sign_q ? {{24{lane_sh[7]}}, lane_sh[7:0]} : {24'd0, lane_sh[7:0]};
      SZ_HALF: ld_fmt = sign_q ? {{16{half_sel[15]}}, half_sel} : {16'd0, half_sel};
      default: ld_fmt = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      oaddr_q   <= '0;
      d0_q      <= '0;
      d1_q      <= '0;
      tgt_q     <= '0;
      bidx_q    <= '0;
      size_q    <= SZ_WORD;
      sign_q    <= 1'b0;
      load_q    <= 1'b1;
      wben_q    <= 1'b0;
      bad_q     <= 1'b0;
      done      <= 1'b0;
      unpred    <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      wb_we     <= 1'b0;
      wb_waddr  <= '0;
      wb_wdata  <= '0;
      br_valid  <= 1'b0;
      br_target <= '0;
    end else begin
      done     <= 1'b0;
      unpred   <= 1'b0;
      rf_we    <= 1'b0;
      wb_we    <= 1'b0;
      br_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q  <= acc_addr;
          oaddr_q <= off_addr;
          d0_q    <= st_data0;
          d1_q    <= st_data1;
          tgt_q   <= tgt_idx;
          bidx_q  <= base_idx;
          size_q  <= size;
          sign_q  <= sign_ext;
          load_q  <= is_load;
          wben_q  <= wben;
          bad_q   <= bad;
          st      <= (cond_ok && !bad) ? S_BEAT0 : S_SKIP;
        end
        S_SKIP: begin
          done   <= 1'b1;
          unpred <= bad_q;
          st     <= S_IDLE;
        end
        S_BEAT0: if (mem_ack) begin
          if (load_q) begin
            if (!pair_q && size_q == SZ_WORD && tgt_q == PC_IDX) begin
              br_valid  <= 1'b1;
              br_target <= mem_rdata;
            end else begin
              rf_we    <= 1'b1;
              rf_waddr <= tgt_q;
              rf_wdata <= ld_fmt;
            end
          end
          if (pair_q) st <= S_BEAT1;
          else begin
            done     <= 1'b1;
            wb_we    <= wben_q;
            wb_waddr <= bidx_q;
            wb_wdata <= oaddr_q;
            st       <= S_IDLE;
          end
        end
        S_BEAT1: if (mem_ack) begin
          if (load_q) begin
            rf_we    <= 1'b1;
            rf_waddr <= tgt_q | 4'd1;
            rf_wdata <= mem_rdata;
          end
          done     <= 1'b1;
          wb_we    <= wben_q;
          wb_waddr <= bidx_q;
          wb_wdata <= oaddr_q;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be));
  a_r11_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);
  a_r7_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BEAT0) && mem_ack && pair_q |=> mem_req && (mem_addr == $past(mem_addr) + 32'd4));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    unpred |-> done && !rf_we && !wb_we && !br_valid);
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && br_valid));
  a_r2_wb_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> done);

endmodule

// File: tb/ldst_addr_unit_tb.sv
module ldst_addr_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start, cond_ok, is_load, literal, pre_idx, up, wb, sign_ext, off_is_reg;
  logic [1:0] size;
  logic [3:0] base_idx, tgt_idx, off_idx;
  logic [11:0] imm;
  logic [31:0] base_val, off_val, pc_val, st_data0, st_data1;
  logic busy, done, unpred, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic rf_we, wb_we, br_valid;
  logic [3:0] rf_waddr, wb_waddr;
  logic [31:0] rf_wdata, wb_wdata, br_target;

  ldst_addr_unit u_dut (.*);

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt_load(input logic [31:0] d, input logic [1:0] a,
                                           input logic [1:0] sz, input logic sg);
    logic [7:0] b;
    logic [15:0] h;
    case (a)
      2'd0: b = d[7:0];
      2'd1: b = d[15:8];
      2'd2: b = d[23:16];
      default: b = d[31:24];
    endcase
    h = a[1] ? d[31:16] : d[15:0];
    if (sz == 2'd0) return sg ? {{24{b[7]}}, b} : {24'd0, b};
    if (sz == 2'd1) return sg ? {{16{h[15]}}, h} : {16'd0, h};
    return d;
  endfunction

  task automatic randomize_fields();
    start = 0;
    cond_ok    = ($urandom % 8) != 0;
    is_load    = $urandom % 2;
    literal    = ($urandom % 6) == 0;
    pre_idx    = $urandom % 2;
    up         = $urandom % 2;
    wb         = $urandom % 2;
    size       = $urandom % 4;
    sign_ext   = (size < 2) ? ($urandom % 2) : 1'b0;
    base_idx   = $urandom % 16;
    tgt_idx    = $urandom % 16;
    off_idx    = $urandom % 16;
    off_is_reg = $urandom % 2;
    imm        = $urandom;
    base_val   = $urandom;
    off_val    = $urandom % 4096;
    pc_val     = $urandom;
    st_data0   = $urandom;
    st_data1   = $urandom;
  endtask

  task automatic run_op(input bit hold);
    logic [31:0] off, base, oa, acc, ea [2], rd [2], lrf_d [4], lwb_d, lbr_d;
    logic [31:0] ba [2], bwd [2];
    logic [3:0]  bbe [2], lrf_a [4], lwb_a, ebe;
    logic        bwe [2];
    logic        narrow, pair, wben, bad, go, fin, got_un, busy0;
    logic [1:0]  sz;
    logic [3:0]  tg, bi;
    logic [31:0] wd0, wd1;
    int nb, nrf, nwb, nbr, cyc, dly, eb;
    bit ld, sg;
    pair   = (size == 2'd3);
    narrow = (size == 2'd1) || pair || sign_ext;
    off    = off_is_reg ? off_val : (narrow ? {24'd0, imm[11:8], imm[3:0]} : {20'd0, imm});
    base   = literal ? (pc_val & 32'hFFFF_FFFC) : base_val;
    oa     = up ? base + off : base - off;
    acc    = (literal || pre_idx) ? oa : base;
    wben   = !literal && (!pre_idx || wb);
    bad    = 0;
    if (wben && base_idx == tgt_idx) bad = 1;
    if (wben && pair && base_idx == tgt_idx + 4'd1) bad = 1;
    if (off_is_reg && off_idx == 4'd15) bad = 1;
    if (pair && (tgt_idx % 2 == 1 || tgt_idx == 4'd14)) bad = 1;
    if (pair && !literal && !pre_idx && wb) bad = 1;
    go = cond_ok && !bad;
    eb = !go ? 0 : (pair ? 2 : 1);
    ea[0] = acc; ea[1] = acc + 4;
    case (size)
      2'd0: ebe = 4'b0001 << acc[1:0];
      2'd1: ebe = acc[1] ? 4'b1100 : 4'b0011;
      default: ebe = 4'b1111;
    endcase
    wd0 = (size == 2'd0) ? {4{st_data0[7:0]}} : (size == 2'd1) ? {2{st_data0[15:0]}} : st_data0;
    wd1 = st_data1;
    sz = size; sg = sign_ext; ld = is_load; tg = tgt_idx; bi = base_idx;

    @(negedge clk); start = 1;
    @(negedge clk);
    start = hold;
    if (hold) randomize_fields();
    start = hold;
    nb = 0; nrf = 0; nwb = 0; nbr = 0; cyc = 0; fin = 0; got_un = 0;
    dly = $urandom % 4; busy0 = busy; lwb_a = 0; lwb_d = 0; lbr_d = 0;
    while (!fin && cyc < 40) begin
      if (rf_we && nrf < 4) begin lrf_a[nrf] = rf_waddr; lrf_d[nrf] = rf_wdata; end
      if (rf_we) nrf++;
      if (wb_we) begin nwb++; lwb_a = wb_waddr; lwb_d = wb_wdata; end
      if (br_valid) begin nbr++; lbr_d = br_target; end
      if (done) begin
        fin = 1; got_un = unpred;
        chk(!busy, "R11 busy low at done", {31'd0, busy}, 32'd0);
      end
      if (cyc == 1) start = 0;
      mem_ack = 0;
      if (mem_req && !fin) begin
        if (dly == 0) begin
          if (nb < 2) begin
            ba[nb] = mem_addr; bbe[nb] = mem_be; bwd[nb] = mem_wdata; bwe[nb] = mem_we;
            rd[nb] = $urandom;
            mem_rdata = rd[nb];
          end
          mem_ack = 1; nb++; dly = $urandom % 4;
        end else dly--;
      end
      if (!fin) begin @(negedge clk); cyc++; end
    end
    mem_ack = 0; start = 0;
    chk(fin, "R11 completion (watchdog)", cyc, 40);
    chk(busy0, "R11 busy after accept", {31'd0, busy0}, 32'd1);
    chk(got_un == bad, "R8 unpredictable flag", {31'd0, got_un}, {31'd0, bad});
    chk(nb == eb, "R9 beat count", nb, eb);
    for (int i = 0; i < nb && i < eb; i++) begin
      chk(ba[i] == ea[i], pair ? "R7 pair beat address" : (literal ? "R3 literal address" : "R1 address"), ba[i], ea[i]);
      chk(bwe[i] == !ld, "R6 write enable", {31'd0, bwe[i]}, {31'd0, !ld});
      chk(bbe[i] == ebe, "R6 byte enables", {28'd0, bbe[i]}, {28'd0, ebe});
      if (!ld) chk(bwd[i] == (i == 0 ? wd0 : wd1), pair ? "R7 pair store data" : "R6 store lanes",
                   bwd[i], (i == 0 ? wd0 : wd1));
    end
    if (go && ld && !pair && sz == 2'd2 && tg == 4'd15) begin
      chk(nbr == 1 && nrf == 0, "R10 branch instead of write", nrf, 0);
      chk(lbr_d == rd[0], "R10 branch target", lbr_d, rd[0]);
    end else if (go && ld) begin
      chk(nbr == 0 && nrf == eb, "R7 register write count", nrf, eb);
      if (nrf >= 1 && eb >= 1) begin
        chk(lrf_a[0] == tg, "R7 first register", {28'd0, lrf_a[0]}, {28'd0, tg});
        chk(lrf_d[0] == fmt_load(rd[0], acc[1:0], pair ? 2'd2 : sz, sg), "R5 load format",
            lrf_d[0], fmt_load(rd[0], acc[1:0], pair ? 2'd2 : sz, sg));
      end
      if (nrf >= 2 && eb == 2) begin
        chk(lrf_a[1] == tg + 4'd1, "R7 second register", {28'd0, lrf_a[1]}, {28'd0, tg + 4'd1});
        chk(lrf_d[1] == rd[1], "R7 second word", lrf_d[1], rd[1]);
      end
    end else begin
      chk(nrf == 0 && nbr == 0, "R9 no register side effect", nrf + nbr, 0);
    end
    if (go && wben) begin
      chk(nwb == 1 && lwb_a == bi, "R2 writeback target", {28'd0, lwb_a}, {28'd0, bi});
      chk(lwb_d == oa, "R2 writeback value", lwb_d, oa);
    end else begin
      chk(nwb == 0, literal ? "R3 no literal writeback" : "R2 no writeback", nwb, 0);
    end
    if (hold) chk(fin, "R11 start while busy ignored", {31'd0, fin}, 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    randomize_fields();
    mem_ack = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done, "R11 reset idle", {29'd0, busy, mem_req, done}, 32'd0);
    rst_n = 1;

    // R3: literal with misaligned PC, subtract, P/W ignored
    randomize_fields();
    literal = 1; cond_ok = 1; is_load = 1; size = 2; sign_ext = 0; off_is_reg = 0;
    pc_val = 32'h0000_1003; up = 0; imm = 12'h010; pre_idx = 0; wb = 1; tgt_idx = 3;
    run_op(0);
    // R1: post-index word store with writeback, R2
    randomize_fields();
    literal = 0; cond_ok = 1; is_load = 0; size = 2; pre_idx = 0; wb = 0; off_is_reg = 0;
    base_idx = 2; tgt_idx = 5; base_val = 32'h100; imm = 12'h004; up = 1;
    run_op(0);
    // R10: word load to index 15
    randomize_fields();
    literal = 0; cond_ok = 1; is_load = 1; size = 2; pre_idx = 1; wb = 0; tgt_idx = 15; off_is_reg = 0;
    run_op(0);
    // R5: signed byte load at each lane, R4 narrow immediate
    for (int a = 0; a < 4; a++) begin
      randomize_fields();
      literal = 0; cond_ok = 1; is_load = 1; size = 0; sign_ext = 1; pre_idx = 1; wb = 0;
      off_is_reg = 0; imm = 12'h300 | 12'(a); base_val = 32'h2000; tgt_idx = 1; base_idx = 2;
      run_op(0);
    end
    // R8: pair with base equal to second register, with writeback
    randomize_fields();
    literal = 0; cond_ok = 1; size = 3; pre_idx = 1; wb = 1; tgt_idx = 4; base_idx = 5; off_is_reg = 0;
    run_op(0);
    // R8: pair at index 14, odd pair, offset register 15, post-index pair with wb
    randomize_fields(); literal = 0; cond_ok = 1; size = 3; tgt_idx = 14; off_is_reg = 0; run_op(0);
    randomize_fields(); literal = 0; cond_ok = 1; size = 3; tgt_idx = 7; off_is_reg = 0; run_op(0);
    randomize_fields(); literal = 0; cond_ok = 1; off_is_reg = 1; off_idx = 15; run_op(0);
    randomize_fields(); literal = 0; cond_ok = 1; size = 3; tgt_idx = 6; base_idx = 1;
    pre_idx = 0; wb = 1; off_is_reg = 0; run_op(0);
    // R7: legal pair load and store, R9 cond fail
    randomize_fields(); literal = 0; cond_ok = 1; is_load = 1; size = 3; tgt_idx = 8; base_idx = 0;
    pre_idx = 1; wb = 1; off_is_reg = 0; run_op(0);
    randomize_fields(); literal = 0; cond_ok = 1; is_load = 0; size = 3; tgt_idx = 2; base_idx = 9;
    pre_idx = 0; wb = 0; off_is_reg = 1; off_idx = 3; run_op(1);
    randomize_fields(); cond_ok = 0; run_op(0);
    // R6: halfword stores at both halves
    for (int h = 0; h < 2; h++) begin
      randomize_fields(); literal = 0; cond_ok = 1; is_load = 0; size = 1; pre_idx = 1; wb = 0;
      off_is_reg = 0; base_val = 32'h4000; imm = h ? 12'h002 : 12'h000; run_op(0);
    end

    for (int n = 0; n < 400; n++) begin
      randomize_fields();
      run_op(($urandom % 4) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule